// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block is the interrupt front end of a small 8-bit processor core. It captures two request sources into sticky flags: a falling edge on an active-low external pin, and a one-cycle overflow pulse from a timer. Each flag is gated by its own enable bit and by a global master enable. Simultaneous requests are resolved by fixed priority. When a request wins, the block sends the program sequencer an acknowledge strobe and a call vector.

Software sees one 8-bit control/status byte on the core's data-memory bus. It can read the byte at any time and can rewrite any implemented bit. Requests are evaluated only on cycles marked by the `t2_edge` strobe, which the core raises once per instruction phase. A request that arrives between two strobes is therefore taken at the next strobe. Service is also held off while the core reports its return-address stack as full. An acknowledge clears the master enable. The core signals a return-with-enable instruction, and only that instruction sets the master enable again.

Top module: `irq_vec_ctl`

## Requirements
- R1: After reset the control byte reads 0x00, `int_ack` is 0 and `vector` is 0x00.
- R2: The control byte is at bus address 0x0B, with bit 0 = master enable, bit 1 = external enable, bit 2 = timer enable, bit 4 = external request flag and bit 5 = timer request flag (1 = enabled/pending). Other addresses read 0x00, and writes to them change nothing.
- R3: Bits 3, 6 and 7 of the control byte always read 0.
- R4: A high-to-low transition on `ext_int_n` sets bit 4. The bit can be read as set after the third rising clock edge following the fall, and not after the second. A rising transition does not set it.
- R5: A `tmr_ovf` pulse sets bit 5 at the next clock edge.
- R6: A request is acknowledged only at an edge where `t2_edge` is 1, the master enable is 1, the request's own enable is 1 and `stack_full` is 0. `int_ack` is then 1 for exactly the following cycle and never for two cycles in a row.
- R7: `vector` becomes 0x04 for an external acknowledge and 0x08 for a timer acknowledge. When both requests are eligible at the same edge, the external request is taken.
- R8: An acknowledge clears the serviced flag and the master enable, and leaves the other flag unchanged.
- R9: A `reti_exec` pulse sets the master enable. Without it the master enable stays clear after service.
- R10: Flags stay set until serviced or written to 0. If a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_int_n | input | 1 | External interrupt pin, active-low, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle |
| t2_edge | input | 1 | Strobe marking the phase edge at which requests are evaluated |
| stack_full | input | 1 | Return-address stack has no free entry |
| reti_exec | input | 1 | Return-with-enable instruction is executing |
| bus_addr | input | 8 | Data-memory address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |
| int_ack | output | 1 | One-cycle acknowledge to the sequencer |
| vector | output | 8 | Call address of the last acknowledged source |

## Verification
A corrupted flag or enable shows up on `bus_rdata` as soon as the control byte is addressed. In the cycle after the next `t2_edge`, the same fault also shows as a missing acknowledge, a spurious one, or a wrong `vector`. A master enable that is not cleared on acknowledge shows as a second `int_ack` at the next strobe while a request is still pending. A broken edge detector shows as bit 4 being set one cycle early or late, or on the wrong transition.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int          DW         = 8;
  localparam logic [7:0]  CTRL_ADDR  = 8'h0B;
  localparam int          B_MASTER   = 0;
  localparam int          B_EN_EXT   = 1;
  localparam int          B_EN_TMR   = 2;
  localparam int          B_FL_EXT   = 4;
  localparam int          B_FL_TMR   = 5;
  localparam logic [7:0]  VEC_EXT    = 8'h04;
  localparam logic [7:0]  VEC_TMR    = 8'h08;

  typedef struct packed {
    logic fl_tmr;
    logic fl_ext;
    logic en_tmr;
    logic en_ext;
    logic master;
  } ctrl_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic fall
);
  localparam int W = STAGES + 1;

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[W-2:0], din_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign fall = sh_q[W-1] & ~sh_q[W-2];
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_vec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          set_ext,
  input  logic          set_tmr,
  input  logic          clr_ext,
  input  logic          clr_tmr,
  input  logic          set_master,
  input  logic          clr_master,
  output ctrl_t         st
);
  ctrl_t st_q, st_d;
  logic  ld;

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      st_d.master = wdata[B_MASTER];
      st_d.en_ext = wdata[B_EN_EXT];
      st_d.en_tmr = wdata[B_EN_TMR];
      st_d.fl_ext = wdata[B_FL_EXT];
      st_d.fl_tmr = wdata[B_FL_TMR];
    end
    if (set_master) st_d.master = 1'b1;
    if (clr_master) st_d.master = 1'b0;
    if (clr_ext)    st_d.fl_ext = 1'b0;
    if (clr_tmr)    st_d.fl_tmr = 1'b0;
    if (set_ext)    st_d.fl_ext = 1'b1;
    if (set_tmr)    st_d.fl_tmr = 1'b1;
  end

  assign ld = wr_en | set_ext | set_tmr | clr_ext | clr_tmr | set_master | clr_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= '0;
    else if (ld) st_q <= st_d;
  end

  assign st = st_q;

  // R5
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_tmr |=> st_q.fl_tmr);

  // R10
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ext && wr_en) |=> st_q.fl_ext);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
(
  input  ctrl_t      st,
  input  logic       t2_edge,
  input  logic       stack_full,
  output logic       grant_ext,
  output logic       grant_tmr,
  output logic [7:0] grant_vec
);
  logic open_q;
  logic req_ext, req_tmr;

  always_comb begin
    open_q    = t2_edge & st.master & ~stack_full;
    req_ext   = st.fl_ext & st.en_ext;
    req_tmr   = st.fl_tmr & st.en_tmr;
    grant_ext = open_q & req_ext;
    grant_tmr = open_q & req_tmr & ~req_ext;
    grant_vec = grant_ext ? VEC_EXT : VEC_TMR;
  end
endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
  import irq_vec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_int_n,
  input  logic          tmr_ovf,
  input  logic          t2_edge,
  input  logic          stack_full,
  input  logic          reti_exec,
  input  logic [7:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          int_ack,
  output logic [7:0]    vector
);
  logic [1:0] rst_sh;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_i = rst_sh[1];

  logic       ext_fall;
  ctrl_t      st;
  logic       g_ext, g_tmr, g_any;
  logic [7:0] g_vec;
  logic       sel;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .din_n(ext_int_n), .fall(ext_fall));

  irq_arbiter u_arb (
    .st(st), .t2_edge(t2_edge), .stack_full(stack_full),
    .grant_ext(g_ext), .grant_tmr(g_tmr), .grant_vec(g_vec));

  assign sel   = (bus_addr == CTRL_ADDR);
  assign g_any = g_ext | g_tmr;

  irq_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_i),
    .wr_en(bus_wr & sel), .wdata(bus_wdata),
    .set_ext(ext_fall), .set_tmr(tmr_ovf),
    .clr_ext(g_ext), .clr_tmr(g_tmr),
    .set_master(reti_exec), .clr_master(g_any),
    .st(st));

  logic       ack_q, ack_d;
  logic [7:0] vec_q, vec_d;

  always_comb begin
    ack_d = g_any;
    vec_d = g_any ? g_vec : vec_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ack_q <= 1'b0;
      vec_q <= 8'h00;
    end else begin
      ack_q <= ack_d;
      if (g_any) vec_q <= vec_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel) begin
      bus_rdata[B_MASTER] = st.master;
      bus_rdata[B_EN_EXT] = st.en_ext;
      bus_rdata[B_EN_TMR] = st.en_tmr;
      bus_rdata[B_FL_EXT] = st.fl_ext;
      bus_rdata[B_FL_TMR] = st.fl_tmr;
    end
  end

  assign int_ack = ack_q;
  assign vector  = vec_q;

  // R6
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_i)
    int_ack |-> ($past(t2_edge) && !$past(stack_full)));

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    int_ack |=> !int_ack);

  // R8
  ack_master_clr_chk: assert property (@(posedge clk) disable iff (!rst_i)
    int_ack |-> !st.master);

  // R7
  prio_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (int_ack && vector == VEC_TMR) |-> !$past(st.fl_ext && st.en_ext));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_rdata[3] == 1'b0) && (bus_rdata[7:6] == 2'b00));
endmodule

// File: tb/sim_irq_vec_ctl.sv
module sim_irq_vec_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_int_n = 1'b1;
  logic       tmr_ovf = 1'b0;
  logic       t2_edge = 1'b0;
  logic       stack_full = 1'b0;
  logic       reti_exec = 1'b0;
  logic [7:0] bus_addr = 8'h0B;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       int_ack;
  logic [7:0] vector;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ext_int_n(ext_int_n), .tmr_ovf(tmr_ovf),
    .t2_edge(t2_edge), .stack_full(stack_full), .reti_exec(reti_exec),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .int_ack(int_ack), .vector(vector));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h0B;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
    bus_addr = 8'h0B;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic fall_ext();
    @(negedge clk); ext_int_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_int_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // strobe t2 and check ack in following cycle
  task automatic strobe(input string req, input logic exp_ack, input logic [7:0] exp_vec);
    @(negedge clk); t2_edge = 1'b1;
    @(negedge clk); t2_edge = 1'b0;
    check(req, {7'd0, int_ack}, {7'd0, exp_ack});
    if (exp_ack) check(req, vector, exp_vec);
    @(negedge clk);
    check(req, {7'd0, int_ack}, 8'h00);
  endtask

  task automatic t_reset();
    rd_chk("R1", 8'h0B, 8'h00);
    check("R1", {7'd0, int_ack}, 8'h00);
    check("R1", vector, 8'h00);
  endtask

  task automatic t_regmap();
    wr_reg(8'h0B, 8'hFF);
    rd_chk("R2 R3", 8'h0B, 8'h37);
    wr_reg(8'h0B, 8'h00);
    rd_chk("R2", 8'h0B, 8'h00);
    wr_reg(8'h0C, 8'hFF);
    rd_chk("R2", 8'h0C, 8'h00);
    rd_chk("R2", 8'h0B, 8'h00);
  endtask

  task automatic t_ext_edge();
    @(negedge clk); ext_int_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk("R4", 8'h0B, 8'h00);
    @(negedge clk);
    rd_chk("R4", 8'h0B, 8'h10);
    wr_reg(8'h0B, 8'h00);
    @(negedge clk); ext_int_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_chk("R4", 8'h0B, 8'h00);
  endtask

  task automatic t_tmr();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
    rd_chk("R5", 8'h0B, 8'h20);
    repeat (4) @(negedge clk);
    rd_chk("R10", 8'h0B, 8'h20);
    wr_reg(8'h0B, 8'h00);
  endtask

  task automatic t_gating();
    pulse_tmr();
    fall_ext();
    wr_reg(8'h0B, 8'h36);
    strobe("R6", 1'b0, 8'h00);
    wr_reg(8'h0B, 8'h37);
    stack_full = 1'b1;
    strobe("R6", 1'b0, 8'h00);
    stack_full = 1'b0;
    repeat (4) @(negedge clk);
    check("R6", {7'd0, int_ack}, 8'h00);
    strobe("R7", 1'b1, 8'h04);
    rd_chk("R8", 8'h0B, 8'h26);
    strobe("R9", 1'b0, 8'h00);
    @(negedge clk); reti_exec = 1'b1;
    @(negedge clk); reti_exec = 1'b0;
    rd_chk("R9", 8'h0B, 8'h27);
    strobe("R7", 1'b1, 8'h08);
    rd_chk("R8", 8'h0B, 8'h06);
  endtask

  task automatic t_own_enable();
    wr_reg(8'h0B, 8'h00);
    fall_ext();
    pulse_tmr();
    wr_reg(8'h0B, 8'h35);
    strobe("R6", 1'b1, 8'h08);
    rd_chk("R8", 8'h0B, 8'h14);
    wr_reg(8'h0B, 8'h00);
  endtask

  task automatic t_race();
    @(negedge clk);
    bus_addr = 8'h0B; bus_wdata = 8'h00; bus_wr = 1'b1; tmr_ovf = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tmr_ovf = 1'b0;
    rd_chk("R10", 8'h0B, 8'h20);
    wr_reg(8'h0B, 8'h00);
    rd_chk("R10", 8'h0B, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_ext_edge();
    t_tmr();
    t_gating();
    t_own_enable();
    t_race();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule